// File: doc/BRIEF.md
# Synchronous Serial Master with Automatic Block Transfer

This block is a clocked serial master built around one 8-bit shift register. It drives a serial clock and a data output and samples a data input. An internal 8-bit divider sets the serial clock rate. A host port gives access to a 32-byte data buffer and to a few configuration and command registers. The host uses the block in one of two ways. In byte mode it shifts buffer entry 0 out and writes the received byte back to that entry. In block mode it streams a programmed number of bits, from 1 to 256, as one unbroken transfer. Transmit bytes are taken from the buffer in ascending order, and each received byte is written back to the entry its transmit byte came from.

A running block transfer can be paused. The pause takes effect at the next byte boundary, where the serial clock is parked high until a resume command arrives. The transfer then continues with the next byte. Bit order (LSB or MSB first), the divider and the length can be changed only while the block is idle.

Top module: `sync_serial_blk`

## Requirements
- R1: After reset, sclk_o and sdo_o are 1, every buffer entry and every configuration register reads 0, and the status register reads 0.
- R2: The serial clock idles high. While a transfer runs, each half period of sclk_o lasts DIV+1 clock cycles, where DIV is the divider register. The first falling edge comes DIV+1 cycles after the first cycle of the transfer (or of the resume).
- R3: sdo_o changes only on a falling edge of sclk_o. It then presents the next bit of the shift register. sdi_i is sampled into the shift register on each rising edge.
- R4: When control bit 0 is 1, bytes are shifted LSB first, and each sampled bit enters at bit 7 while the rest move right. When it is 0, bytes are shifted MSB first, and each sampled bit enters at bit 0 while the rest move left.
- R5: Writing command bit 0 while idle starts byte mode. Buffer entry 0 is shifted for 8 bits, and the resulting shift register value is written back to entry 0. No other entry changes.
- R6: Writing command bit 1 while idle starts block mode for L+1 bits, where L is the length register. At the end of each byte, and after the last bit, the shift register value is written to buffer entry k (k = completed bit index / 8). At each byte end that is not the last, entry k+1 is loaded. When a final byte is partial, its stored value keeps the untransmitted transmit bits.
- R7: Status bit 0 (busy) is 1 while a transfer is running or paused. Status bit 1 (done) is set at the rising edge that completes the last bit and is cleared by a start.
- R8: Writing command bit 2 during a running transfer halts it after the next byte boundary that has bits left to send. sclk_o then stays high and status bit 2 (paused) is 1. If no such boundary remains, the transfer completes normally.
- R9: Writing command bit 3 while paused clears status bit 2 and continues the transfer with the next byte, using the timing of R2.
- R10: While busy, writes to the control, divider and length registers and start commands are ignored. A resume command is ignored unless the transfer is paused.
- R11: Host map: addresses 0 to 31 hold the buffer; 32 holds control (bit 0 sets LSB first); 33 the divider; 34 the length; 35 is the write-only command register (reads 0); 36 is read-only status. host_rdata reflects host_addr combinationally, and writes take effect at the clock edge where host_we is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host register or buffer address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
The bench runs a reference model against the design every cycle. It targets the divider at 0, where each serial half period lasts one cycle; a design with an off-by-one in its counter would stretch or shorten every edge. It also targets a full 256-bit stream, which ends on the exact last buffer entry. A bit counter that wrapped early would stop short or write to the wrong entry. It targets a partial final byte, where a wrong merge would lose the untransmitted bits. For pause, it issues a pause request during the last byte, which must not halt. It also issues a config write while paused, which must not land, and a resume, whose first falling edge must come a full half period later. Bit order is checked against the sdo_o sequence seen at the pins, without relying on the buffer.

// File: rtl/sser_pkg.sv
package sser_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;

  // Register offsets above the buffer
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_DIV  = 1;
  localparam int unsigned OFS_LEN  = 2;
  localparam int unsigned OFS_CMD  = 3;
  localparam int unsigned OFS_STAT = 4;

  // Command bits
  localparam int unsigned CMD_BYTE   = 0;
  localparam int unsigned CMD_BLOCK  = 1;
  localparam int unsigned CMD_PAUSE  = 2;
  localparam int unsigned CMD_RESUME = 3;

  // Shift register after one sampled bit
  function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic din,
                                          input logic lsb_first);
    if (lsb_first) return {din, cur[7:1]};
    return {cur[6:0], din};
  endfunction

  // Bit presented on the data line
  function automatic logic out_bit(input logic [7:0] cur, input logic lsb_first);
    return lsb_first ? cur[0] : cur[7];
  endfunction

  // A completed bit index closes a byte when its low three bits are all ones
  function automatic logic ends_byte(input logic [2:0] low_bits);
    return low_bits == 3'd7;
  endfunction

endpackage

// File: rtl/sser_baud.sv
module sser_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall_evt,
  output logic             rise_evt
);
  logic [DIV_W-1:0] phase_q;
  logic             sclk_q;
  logic             tick;

  assign tick     = run && (phase_q == div);
  assign fall_evt = tick && sclk_q;
  assign rise_evt = tick && !sclk_q;
  assign sclk     = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      sclk_q  <= 1'b1;
    end else if (!run) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= '0;
      sclk_q  <= ~sclk_q;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // R2: the serial clock rests high whenever no transfer is running
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> sclk_q);

  // R2: the phase count never passes the divider
  p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= div);

  // R2: the clock only moves on a divider tick
  p_sclk_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sclk_q));

endmodule

// File: rtl/sser_shift.sv
module sser_shift
  import sser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lsb_first,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       shift,
  input  logic       fall_evt,
  input  logic       sdi,
  output logic [7:0] sreg_nxt,
  output logic       sdo
);
  logic [7:0] sreg_q;
  logic       sdo_q;

  assign sreg_nxt = shift_in(sreg_q, sdi, lsb_first);
  assign sdo      = sdo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q <= '0;
      sdo_q  <= 1'b1;
    end else begin
      if (load)       sreg_q <= load_val;
      else if (shift) sreg_q <= sreg_nxt;
      if (fall_evt)   sdo_q  <= out_bit(sreg_q, lsb_first);
    end
  end

  // R3: data out holds between falling edges
  p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(sdo_q));

  // R3: the register is never shifted and driven out in the same cycle
  p_edges_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift && fall_evt));

endmodule

// File: rtl/sser_seq.sv
module sser_seq
  import sser_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_byte,
  input  logic             start_blk,
  input  logic             pause_cmd,
  input  logic             resume_cmd,
  input  logic [CNT_W-1:0] len,
  input  logic             rise_evt,
  output logic             run,
  output logic             busy,
  output logic             paused,
  output logic             done,
  output logic             load,
  output logic [IDX_W-1:0] load_idx,
  output logic             shift,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] bitcnt_q;
  logic [CNT_W-1:0] last_q;
  logic             preq_q;
  logic             done_q;
  logic             go;
  logic             at_last;
  logic             boundary;
  logic [IDX_W-1:0] cur_idx;

  assign cur_idx  = bitcnt_q[CNT_W-1:3];
  assign at_last  = bitcnt_q == last_q;
  assign boundary = ends_byte(bitcnt_q[2:0]);
  assign go       = (start_byte || start_blk) && (state_q == ST_IDLE);

  assign run    = state_q == ST_RUN;
  assign paused = state_q == ST_HOLD;
  assign busy   = state_q != ST_IDLE;
  assign done   = done_q;
  assign shift  = rise_evt;

  always_comb begin
    load     = go || (rise_evt && boundary && !at_last);
    load_idx = go ? '0 : cur_idx + 1'b1;
    wr_en    = rise_evt && (at_last || boundary);
    wr_idx   = cur_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      last_q   <= '0;
      preq_q   <= 1'b0;
      done_q   <= 1'b0;
    end else if (go) begin
      state_q  <= ST_RUN;
      bitcnt_q <= '0;
      last_q   <= start_blk ? len : CNT_W'(7);
      preq_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (rise_evt) begin
            bitcnt_q <= bitcnt_q + 1'b1;
            if (at_last) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              preq_q  <= 1'b0;
            end else if (boundary && preq_q) begin
              state_q <= ST_HOLD;
              preq_q  <= 1'b0;
            end
          end
          if (pause_cmd) preq_q <= 1'b1;
        end
        ST_HOLD: begin
          if (resume_cmd) state_q <= ST_RUN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: a pause only begins right after a whole byte
  p_hold_on_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> (bitcnt_q[2:0] == 3'd0) && (bitcnt_q != '0));

  // R6: the bit index never passes the programmed last bit
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> bitcnt_q <= last_q);

  // R7: done appears only after a rising serial edge
  p_done_at_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(rise_evt));

  // R7: done and busy are never both set
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

  // R9: leaving a pause needs a resume command
  p_resume_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    paused && !resume_cmd |=> paused);

endmodule

// File: rtl/sser_regs.sv
module sser_regs
  import sser_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 32,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              busy,
  input  logic              paused,
  input  logic              done,
  input  logic              int_we,
  input  logic [IDX_W-1:0]  int_widx,
  input  logic [7:0]        int_wdata,
  input  logic [IDX_W-1:0]  int_ridx,
  output logic [7:0]        int_rdata,
  output logic              lsb_first,
  output logic [DIV_W-1:0]  div,
  output logic [CNT_W-1:0]  len,
  output logic              cmd_byte,
  output logic              cmd_blk,
  output logic              cmd_pause,
  output logic              cmd_resume
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BUF_BYTES + OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(BUF_BYTES + OFS_DIV);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(BUF_BYTES + OFS_LEN);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(BUF_BYTES + OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BUF_BYTES + OFS_STAT);

  logic [7:0]       buf_q [BUF_BYTES];
  logic             lsb_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] len_q;
  logic             in_buf;
  logic             cfg_we;
  logic             cmd_we;

  assign in_buf = host_addr < ADDR_W'(BUF_BYTES);
  assign cfg_we = host_we && !busy;
  assign cmd_we = host_we && (host_addr == A_CMD);

  assign cmd_byte   = cmd_we && host_wdata[CMD_BYTE] && !host_wdata[CMD_BLOCK];
  assign cmd_blk    = cmd_we && host_wdata[CMD_BLOCK];
  assign cmd_pause  = cmd_we && host_wdata[CMD_PAUSE];
  assign cmd_resume = cmd_we && host_wdata[CMD_RESUME];

  assign lsb_first = lsb_q;
  assign div       = div_q;
  assign len       = len_q;
  assign int_rdata = buf_q[int_ridx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= '0;
    end else begin
      if (host_we && in_buf) buf_q[host_addr[IDX_W-1:0]] <= host_wdata;
      // the shift engine wins a collision on the same entry
      if (int_we) buf_q[int_widx] <= int_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lsb_q <= 1'b0;
      div_q <= '0;
      len_q <= '0;
    end else if (cfg_we) begin
      if (host_addr == A_CTRL) lsb_q <= host_wdata[0];
      if (host_addr == A_DIV)  div_q <= host_wdata[DIV_W-1:0];
      if (host_addr == A_LEN)  len_q <= host_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (in_buf)                   host_rdata = buf_q[host_addr[IDX_W-1:0]];
    else if (host_addr == A_CTRL) host_rdata = {7'd0, lsb_q};
    else if (host_addr == A_DIV)  host_rdata = 8'(div_q);
    else if (host_addr == A_LEN)  host_rdata = 8'(len_q);
    else if (host_addr == A_STAT) host_rdata = {5'd0, paused, done, busy};
  end

  // R10: configuration holds still through a busy stretch
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(div_q) && $stable(len_q) && $stable(lsb_q));

endmodule

// File: rtl/sync_serial_blk.sv
module sync_serial_blk
  import sser_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 32,
  parameter int unsigned DIV_W     = 8,
  localparam int unsigned IDX_W    = $clog2(BUF_BYTES),
  localparam int unsigned ADDR_W   = IDX_W + 1,
  localparam int unsigned CNT_W    = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  logic             lsb_first;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] len;
  logic             cmd_byte, cmd_blk, cmd_pause, cmd_resume;
  logic             run, busy, paused, done;
  logic             load, shift, wr_en;
  logic [IDX_W-1:0] load_idx, wr_idx;
  logic [7:0]       load_val, sreg_nxt;
  logic             fall_evt, rise_evt;

  sser_regs #(
    .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .DIV_W(DIV_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy(busy), .paused(paused), .done(done),
    .int_we(wr_en), .int_widx(wr_idx), .int_wdata(sreg_nxt),
    .int_ridx(load_idx), .int_rdata(load_val),
    .lsb_first(lsb_first), .div(div), .len(len),
    .cmd_byte(cmd_byte), .cmd_blk(cmd_blk),
    .cmd_pause(cmd_pause), .cmd_resume(cmd_resume)
  );

  sser_seq #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_byte(cmd_byte), .start_blk(cmd_blk),
    .pause_cmd(cmd_pause), .resume_cmd(cmd_resume),
    .len(len), .rise_evt(rise_evt),
    .run(run), .busy(busy), .paused(paused), .done(done),
    .load(load), .load_idx(load_idx), .shift(shift),
    .wr_en(wr_en), .wr_idx(wr_idx)
  );

  sser_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div),
    .sclk(sclk_o), .fall_evt(fall_evt), .rise_evt(rise_evt)
  );

  sser_shift u_shift (
    .clk(clk), .rst_n(rst_n), .lsb_first(lsb_first),
    .load(load), .load_val(load_val), .shift(shift),
    .fall_evt(fall_evt), .sdi(sdi_i),
    .sreg_nxt(sreg_nxt), .sdo(sdo_o)
  );

  // R8: a paused transfer keeps the serial clock parked high
  p_hold_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> sclk_o && !fall_evt && !rise_evt);

  // R5: the buffer is written only at a rising serial edge
  p_write_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> rise_evt);

endmodule

// File: tb/sync_serial_blk_test.sv
module sync_serial_blk_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       sclk_o, sdo_o;
  logic       sdi_i = 1'b0;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  int sdi_mode = 0;          // 0 pseudo-random, 1 constant zero
  int lfsr = 32'h1d2c3b4a;

  sync_serial_blk uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  int m_run, m_hold, m_pc, m_sclk, m_sdo, m_sreg, m_bit, m_last;
  int m_done, m_preq, m_div, m_len, m_lsb;
  int m_buf [32];

  function automatic int model_read(int a);
    if (a < 32) return m_buf[a];
    case (a)
      32: return m_lsb;
      33: return m_div;
      34: return m_len;
      36: return (m_hold << 2) | (m_done << 1) | ((m_run | m_hold) ? 1 : 0);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_hold = 0; m_pc = 0; m_sclk = 1; m_sdo = 1; m_sreg = 0;
      m_bit = 0; m_last = 0; m_done = 0; m_preq = 0; m_div = 0; m_len = 0; m_lsb = 0;
      foreach (m_buf[i]) m_buf[i] = 0;
    end else begin
      int busy0, run0, hold0, sh;
      busy0 = m_run | m_hold; run0 = m_run; hold0 = m_hold;
      if (m_run) begin
        if (m_pc == m_div) begin
          m_pc = 0;
          if (m_sclk) begin
            m_sclk = 0;
            m_sdo = m_lsb ? (m_sreg & 1) : ((m_sreg >> 7) & 1);
          end else begin
            m_sclk = 1;
            sh = m_lsb ? ((m_sreg >> 1) | (int'(sdi_i) << 7))
                       : (((m_sreg << 1) & 255) | int'(sdi_i));
            if (m_bit == m_last || m_bit % 8 == 7) m_buf[m_bit / 8] = sh;
            if (m_bit == m_last) begin
              m_run = 0; m_done = 1; m_preq = 0;
            end else if (m_bit % 8 == 7) begin
              m_sreg = m_buf[m_bit / 8 + 1];
              if (m_preq) begin m_run = 0; m_hold = 1; m_preq = 0; end
            end else m_sreg = sh;
            m_bit++;
          end
        end else m_pc++;
      end
      if (host_we) begin
        int a, d;
        a = int'(host_addr); d = int'(host_wdata);
        if (a < 32) m_buf[a] = d;
        else if (a == 32 && busy0 == 0) m_lsb = d & 1;
        else if (a == 33 && busy0 == 0) m_div = d;
        else if (a == 34 && busy0 == 0) m_len = d;
        else if (a == 35) begin
          if ((d & 3) != 0 && busy0 == 0) begin
            m_last = (d & 2) ? m_len : 7;
            m_run = 1; m_pc = 0; m_bit = 0; m_sreg = m_buf[0]; m_done = 0; m_preq = 0;
          end
          if ((d & 4) && run0) m_preq = 1;
          if ((d & 8) && hold0) begin m_hold = 0; m_run = 1; m_pc = 0; end
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  always @(negedge clk) begin
    lfsr = (lfsr << 1) ^ (((lfsr >> 31) ^ (lfsr >> 21) ^ (lfsr >> 1) ^ lfsr) & 1);
    sdi_i <= (sdi_mode == 0) ? lfsr[3] : 1'b0;
  end

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // every-cycle comparison, sampled 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check("R2 sclk", int'(sclk_o), m_sclk);
      check("R3 sdo", int'(sdo_o), m_sdo);
      check("R11 rdata", int'(host_rdata), model_read(int'(host_addr)));
    end
  end

  // pin-level capture of the bits sent, taken at each rising serial edge
  int cap = 0, capn = 0;
  always @(posedge sclk_o) begin
    if (rst_n && capn < 8) begin
      cap = cap | (int'(sdo_o) << capn);
      capn++;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 6'(a); host_wdata = 8'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    host_addr = 6'(a);
    #1 v = int'(host_rdata);
  endtask

  task automatic wait_idle();
    int v;
    for (int k = 0; k < 30000; k++) begin
      rd(36, v);
      if ((v & 1) == 0) break;
    end
  endtask

  task automatic check_all_buf(string tag);
    int v;
    for (int i = 0; i < 32; i++) begin
      rd(i, v);
      check(tag, v, m_buf[i]);
    end
  endtask

  function automatic int rev8(int x);
    int r = 0;
    for (int i = 0; i < 8; i++) if ((x >> i) & 1) r |= 1 << (7 - i);
    return r;
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    int v, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sclk", int'(sclk_o), 1);
    check("R1 sdo", int'(sdo_o), 1);
    rd(36, v); check("R1 status", v, 0);
    rd(33, v); check("R1 div", v, 0);
    rd(5, v);  check("R1 buffer", v, 0);

    for (int i = 0; i < 32; i++) wr(i, (i * 37 + 11) & 255);

    // R5 byte mode, MSB first, divider 0, with pin-level order check (R4)
    sdi_mode = 1;
    wr(0, 8'hA1);
    cap = 0; capn = 0;
    wr(35, 1);
    wait_idle();
    check("R4 msb order at pins", cap, rev8(8'hA1));
    rd(0, v); check("R5 entry0 zero input", v, 0);
    rd(36, v); check("R7 done after byte", v, 2);

    // R4 LSB first, divider 3
    wr(32, 1); wr(33, 3); wr(0, 8'h3C);
    cap = 0; capn = 0;
    wr(35, 1);
    wait_idle();
    check("R4 lsb order at pins", cap, 8'h3C);

    // R5 with random input
    sdi_mode = 0;
    wr(32, 0); wr(33, 2);
    wr(35, 1);
    wait_idle();
    rd(0, v); check("R5 entry0", v, m_buf[0]);
    rd(1, v); check("R5 entry1 untouched", v, m_buf[1]);

    // R6 full 256-bit stream, divider 1
    wr(33, 1); wr(34, 255);
    wr(35, 2);
    rd(36, v); check("R7 busy during block", v & 1, 1);
    wait_idle();
    check_all_buf("R6 256-bit buffer");

    // R6 partial final byte: 13 bits, LSB first, divider 0
    wr(32, 1); wr(33, 0); wr(34, 12);
    wr(35, 2);
    wait_idle();
    rd(1, v); check("R6 partial byte", v, m_buf[1]);
    rd(2, v); check("R6 past end untouched", v, m_buf[2]);

    // R8 / R9 / R10 pause and resume
    wr(32, 0); wr(33, 2); wr(34, 63);
    wr(35, 2);
    wr(35, 4);
    for (int k = 0; k < 400; k++) begin
      rd(36, v);
      if (v & 4) break;
    end
    check("R8 paused flag", v, 5);
    hi = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sclk_o) hi++;
    end
    check("R8 clock parked high", hi, 40);
    wr(33, 9); rd(33, v); check("R10 div frozen", v, 2);
    wr(35, 1); rd(36, v); check("R10 start ignored", v, 5);
    wr(35, 8);
    rd(36, v); check("R9 resumed", v, 1);
    wait_idle();
    rd(36, v); check("R7 done after resume", v, 2);
    check_all_buf("R9 buffer after resume");

    // R8 pause during the only byte: completes normally
    wr(34, 7);
    wr(35, 2);
    wr(35, 4);
    wait_idle();
    rd(36, v); check("R8 no halt in last byte", v, 2);

    // R10 resume while idle ignored
    wr(35, 8);
    rd(36, v); check("R10 resume ignored", v, 2);
    check("R10 clock still high", int'(sclk_o), 1);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule